// File: doc/BRIEF.md
# ATA Cycle Strobe Timer

This block times the read and write strobes of a parallel ATA host port. A small byte-wide register space holds one timing byte for programmed I/O cycles, one for multiword DMA cycles, one Ultra DMA timing byte per device, and a clock-mode byte. The programmed I/O and multiword DMA bytes are shared by both devices. The Ultra DMA bytes and the clock and enable selections are kept separately for each device.

A transfer request names the target device, the cycle kind and the direction. The block then pulls the matching strobe low for the programmed active time and releases it for the programmed recovery time. Both times are counted in units of two pulses of the reference clock enable. A one-cycle done pulse closes the cycle. The Ultra DMA values and the per-device clock bits are only stored here and driven out to a separate engine. Data movement and the device handshake belong to other blocks.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset, every timing register reads 0, both strobes are high (deasserted), and busy, done, cycFast and all Ultra DMA and clock outputs are 0.
- R2: Offset 0x10 (programmed I/O timing) and offset 0x11 (multiword DMA timing) store all 8 bits. Offsets 0x12 and 0x13 (Ultra DMA timing for device 0 and device 1) store bits 7, 6:4 and 2:0 and read bit 3 as 0. Offset 0x14 (clock mode) stores bits 0, 1, 4 and 5 and reads the other bits as 0.
- R3: A read of any other offset returns 0, and a write to any other offset changes no register.
- R4: In a cycle, the selected strobe is low from the clock after acceptance for exactly 2*(A+1) reference-enable pulses. A is bits 7:4 of offset 0x10 for kind 0 (programmed I/O) or of offset 0x11 for kind 1 (multiword DMA). Time advances only on pulses of refEn.
- R5: After the active phase, the strobe is high for exactly 2*(R+1) reference-enable pulses before done. R is bits 3:0 of the same timing byte.
- R6: startWrite=1 selects wrStrobeN and startWrite=0 selects rdStrobeN. The other strobe stays high for the whole cycle.
- R7: busy rises on the clock that accepts a request and stays high through the single-cycle done pulse. done follows the last recovery unit by one clock, and busy is low on the clock after done.
- R8: A request presented while busy is ignored. It neither restarts nor lengthens the cycle in progress.
- R9: The timing counts are captured when the cycle is accepted. A register write during a cycle affects only later cycles.
- R10: udmaTim0 and udmaTim1 always show the stored bytes at offsets 0x12 and 0x13. udmaEn[d] shows clock-mode bit 4+d, and devFast[d] shows clock-mode bit d.
- R11: While busy in a multiword DMA cycle, cycFast equals clock-mode bit d of the target device d. It is 0 in programmed I/O cycles and whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refEn | input | 1 | Reference clock enable; two pulses make one timing unit |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register offset |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data for regAddr |
| startReq | input | 1 | Cycle request, taken only while idle |
| startKind | input | 1 | 0 = programmed I/O, 1 = multiword DMA |
| startDev | input | 1 | Target device (0 or 1) |
| startWrite | input | 1 | 1 = write strobe, 0 = read strobe |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle pulse at the end of a cycle |
| rdStrobeN | output | 1 | Read strobe, active low |
| wrStrobeN | output | 1 | Write strobe, active low |
| cycFast | output | 1 | Fast timebase selected for the current cycle |
| udmaTim0 | output | 8 | Ultra DMA timing byte, device 0 |
| udmaTim1 | output | 8 | Ultra DMA timing byte, device 1 |
| udmaEn | output | 2 | Ultra DMA enable per device |
| devFast | output | 2 | Fast timebase select per device |

## Verification
The hardest case to reach from the ports is a timing write that lands while a strobe is already low. The test must show that this write changes nothing in the running cycle but does change the next one. The cycle task therefore issues the register write on the first clock of the active phase. It then measures both phases against the old counts, runs a second cycle and measures that one against the new counts. To show that the count depends only on reference-enable pulses, the bench measures each phase in refEn pulses rather than in clocks, and it repeats the cycles with refEn present every cycle, every second cycle and every third cycle.

// File: rtl/ata_tmg_pkg.sv
package ata_tmg_pkg;

  localparam int REG_W  = 8;
  localparam int ADDR_W = 8;

  // register offsets (offset of device d's Ultra DMA byte is OFF_UDMA0 + d)
  localparam int OFF_PIO   = 'h10;
  localparam int OFF_MW    = 'h11;
  localparam int OFF_UDMA0 = 'h12;
  localparam int OFF_CLK   = 'h14;

  // implemented bits
  localparam logic [REG_W-1:0] UDMA_MASK = 8'hF7;
  localparam logic [REG_W-1:0] CLK_MASK  = 8'h33;
  localparam int CLK_SEL_LSB = 0;
  localparam int CLK_EN_LSB  = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_REC  = 2'd2,
    ST_FIN  = 2'd3
  } tmgState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;    // capture counts and cycle attributes
    logic loadRec;  // load recovery count
    logic decr;     // count down one unit
    logic clrDiv;   // hold unit divider cleared
  } tmgCtl_t;

endpackage

// File: rtl/ata_tmg_datapath.sv
module ata_tmg_datapath
  import ata_tmg_pkg::*;
#(
  parameter int DW      = REG_W,
  parameter int AW      = ADDR_W,
  parameter int NUM_DEV = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  refEn,
  input  logic                  regWe,
  input  logic [AW-1:0]         regAddr,
  input  logic [DW-1:0]         regWdata,
  output logic [DW-1:0]         regRdata,
  input  tmgCtl_t               ctl,
  input  logic                  startKind,
  input  logic [((NUM_DEV > 1) ? $clog2(NUM_DEV) : 1)-1:0] startDev,
  input  logic                  startWrite,
  output logic                  tick,
  output logic                  cntZero,
  output logic                  curWrite,
  output logic                  curFast,
  output logic [NUM_DEV*DW-1:0] udmaTimFlat,
  output logic [NUM_DEV-1:0]    udmaEn,
  output logic [NUM_DEV-1:0]    devFast
);

  localparam int CNT_W = DW / 2;

  logic [DW-1:0]    pioReg;
  logic [DW-1:0]    mwReg;
  logic [DW-1:0]    clkReg;
  logic [DW-1:0]    udmaReg [NUM_DEV];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] curRec;
  logic             divTog;
  logic [DW-1:0]    selTim;

  // shared timing registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pioReg <= '0;
      mwReg  <= '0;
      clkReg <= '0;
    end else if (regWe) begin
      if (regAddr == AW'(OFF_PIO)) pioReg <= regWdata;
      if (regAddr == AW'(OFF_MW))  mwReg  <= regWdata;
      if (regAddr == AW'(OFF_CLK)) clkReg <= regWdata & CLK_MASK;
    end
  end

  // per-device Ultra DMA bytes and clock-mode fan-out
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) udmaReg[d] <= '0;
      else if (regWe && regAddr == AW'(OFF_UDMA0 + d)) udmaReg[d] <= regWdata & UDMA_MASK;
    end
    assign udmaTimFlat[d*DW +: DW] = udmaReg[d];
    assign udmaEn[d]  = clkReg[CLK_EN_LSB + d];
    assign devFast[d] = clkReg[CLK_SEL_LSB + d];
  end

  // read decode, undefined offsets give zero
  always_comb begin
    regRdata = '0;
    if (regAddr == AW'(OFF_PIO)) regRdata = pioReg;
    if (regAddr == AW'(OFF_MW))  regRdata = mwReg;
    if (regAddr == AW'(OFF_CLK)) regRdata = clkReg;
    for (int d = 0; d < NUM_DEV; d++) begin
      if (regAddr == AW'(OFF_UDMA0 + d)) regRdata = udmaReg[d];
    end
  end

  assign selTim = startKind ? mwReg : pioReg;

  // cycle attributes captured at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curRec   <= '0;
      curWrite <= 1'b0;
      curFast  <= 1'b0;
    end else if (ctl.latch) begin
      curRec   <= selTim[CNT_W-1:0];
      curWrite <= startWrite;
      curFast  <= startKind & clkReg[CLK_SEL_LSB + int'(startDev)];
    end
  end

  // unit down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (ctl.latch)   cnt <= selTim[DW-1 -: CNT_W];
    else if (ctl.loadRec) cnt <= curRec;
    else if (ctl.decr)    cnt <= cnt - 1'b1;
  end

  // divide the reference enable by two to form the unit tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           divTog <= 1'b0;
    else if (ctl.clrDiv) divTog <= 1'b0;
    else if (refEn)      divTog <= ~divTog;
  end

  assign tick    = refEn & divTog;
  assign cntZero = (cnt == '0);

endmodule

// File: rtl/ata_tmg_ctrl.sv
module ata_tmg_ctrl
  import ata_tmg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    tick,
  input  logic    cntZero,
  output tmgCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    strobeOn
);

  tmgState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt    = state;
    ctl         = '0;
    ctl.clrDiv  = 1'b1;
    case (state)
      ST_IDLE: begin
        if (startReq) begin
          ctl.latch = 1'b1;
          stateNxt  = ST_ACT;
        end
      end
      ST_ACT: begin
        ctl.clrDiv = 1'b0;
        if (tick) begin
          if (cntZero) begin
            ctl.loadRec = 1'b1;
            stateNxt    = ST_REC;
          end else begin
            ctl.decr = 1'b1;
          end
        end
      end
      ST_REC: begin
        ctl.clrDiv = 1'b0;
        if (tick) begin
          if (cntZero) stateNxt = ST_FIN;
          else         ctl.decr = 1'b1;
        end
      end
      ST_FIN:  stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_FIN);
  assign strobeOn = (state == ST_ACT);

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
  import ata_tmg_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          refEn,
  input  logic          regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [DW-1:0] regWdata,
  output logic [DW-1:0] regRdata,
  input  logic          startReq,
  input  logic          startKind,
  input  logic          startDev,
  input  logic          startWrite,
  output logic          busy,
  output logic          done,
  output logic          rdStrobeN,
  output logic          wrStrobeN,
  output logic          cycFast,
  output logic [DW-1:0] udmaTim0,
  output logic [DW-1:0] udmaTim1,
  output logic [1:0]    udmaEn,
  output logic [1:0]    devFast
);

  localparam int NUM_DEV = 2;

  tmgCtl_t                ctl;
  logic                   tick;
  logic                   cntZero;
  logic                   curWrite;
  logic                   curFast;
  logic                   strobeOn;
  logic [NUM_DEV*DW-1:0]  udmaTimFlat;

  ata_tmg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .tick     (tick),
    .cntZero  (cntZero),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done),
    .strobeOn (strobeOn)
  );

  ata_tmg_datapath #(.DW(DW), .AW(AW), .NUM_DEV(NUM_DEV)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .refEn       (refEn),
    .regWe       (regWe),
    .regAddr     (regAddr),
    .regWdata    (regWdata),
    .regRdata    (regRdata),
    .ctl         (ctl),
    .startKind   (startKind),
    .startDev    (startDev),
    .startWrite  (startWrite),
    .tick        (tick),
    .cntZero     (cntZero),
    .curWrite    (curWrite),
    .curFast     (curFast),
    .udmaTimFlat (udmaTimFlat),
    .udmaEn      (udmaEn),
    .devFast     (devFast)
  );

  assign udmaTim0  = udmaTimFlat[0*DW +: DW];
  assign udmaTim1  = udmaTimFlat[1*DW +: DW];
  assign rdStrobeN = ~(strobeOn & ~curWrite);
  assign wrStrobeN = ~(strobeOn & curWrite);
  assign cycFast   = curFast & busy;

endmodule

// File: rtl/ata_strobe_timer_chk.sv
module ata_strobe_timer_chk (
  input logic clk,
  input logic rstN,
  input logic refEn,
  input logic busy,
  input logic done,
  input logic rdStrobeN,
  input logic wrStrobeN,
  input logic cycFast
);

  // R6: never both strobes at once
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdStrobeN && !wrStrobeN));

  // R4: a strobe is low only inside a cycle
  a_r4_strobe_in_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStrobeN || !wrStrobeN) |-> busy);

  // R4: without a reference pulse an ongoing cycle keeps its strobes
  a_r4_hold_without_ref: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !refEn) |=> ($stable(rdStrobeN) && $stable(wrStrobeN)));

  // R7: done only while busy
  a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  // R7: done lasts one cycle and busy drops after it
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R7, R8: busy cannot fall before done
  a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R11: no timebase indication while idle
  a_r11_idle_not_fast: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cycFast);

endmodule

bind ata_strobe_timer ata_strobe_timer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .refEn     (refEn),
  .busy      (busy),
  .done      (done),
  .rdStrobeN (rdStrobeN),
  .wrStrobeN (wrStrobeN),
  .cycFast   (cycFast)
);

// File: tb/tb_ata_strobe_timer.sv
`timescale 1ns/1ps
module tb_ata_strobe_timer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refEn = 1'b1;
  logic       regWe = 1'b0;
  logic [7:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic       startReq = 1'b0;
  logic       startKind = 1'b0;
  logic       startDev = 1'b0;
  logic       startWrite = 1'b0;
  logic       busy, done, rdStrobeN, wrStrobeN, cycFast;
  logic [7:0] udmaTim0, udmaTim1;
  logic [1:0] udmaEn, devFast;

  int nChecks = 0;
  int nFails  = 0;
  int refMode = 0;

  always #10 clk = ~clk;

  ata_strobe_timer dut (
    .clk(clk), .rstN(rstN), .refEn(refEn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .startReq(startReq),
    .startKind(startKind), .startDev(startDev), .startWrite(startWrite),
    .busy(busy), .done(done), .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN),
    .cycFast(cycFast), .udmaTim0(udmaTim0), .udmaTim1(udmaTim1),
    .udmaEn(udmaEn), .devFast(devFast)
  );

  // reference enable pattern, changed shortly after each rising edge
  initial begin
    int phase = 0;
    forever begin
      @(posedge clk);
      #2;
      phase++;
      case (refMode)
        0:       refEn = 1'b1;
        1:       refEn = phase[0];
        default: refEn = (phase % 3 == 0);
      endcase
    end
  end

  task automatic chkEq(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic runCycle(input bit kind, input bit dev, input bit wr,
                          input int expA, input int expR, input bit expFast,
                          input bit holdStart, input bit doMid,
                          input logic [7:0] midAddr, input logic [7:0] midData,
                          input string req);
    int lowPulses = 0, highPulses = 0, otherBad = 0, fastBad = 0, iter = 0;
    @(negedge clk);
    startReq = 1'b1; startKind = kind; startDev = dev; startWrite = wr;
    @(negedge clk);
    if (!holdStart) startReq = 1'b0;
    chkEq(req, "strobe low after accept", int'(wr ? wrStrobeN : rdStrobeN), 0);
    while ((wr ? wrStrobeN : rdStrobeN) == 1'b0 && iter < 400) begin
      if (refEn) lowPulses++;
      if ((wr ? rdStrobeN : wrStrobeN) != 1'b1) otherBad++;
      if (cycFast != expFast) fastBad++;
      if (doMid && iter == 0) begin regWe = 1'b1; regAddr = midAddr; regWdata = midData; end
      if (iter == 1) regWe = 1'b0;
      iter++;
      @(negedge clk);
    end
    regWe = 1'b0;
    iter = 0;
    while (!done && iter < 400) begin
      if (refEn) highPulses++;
      if (!rdStrobeN || !wrStrobeN) otherBad++;
      if (cycFast != expFast) fastBad++;
      iter++;
      @(negedge clk);
    end
    chkEq(req, "active refEn pulses (R4)", lowPulses, 2 * (expA + 1));
    chkEq(req, "recovery refEn pulses (R5)", highPulses, 2 * (expR + 1));
    chkEq("R6", "other strobe low count", otherBad, 0);
    chkEq("R11", "cycFast mismatches", fastBad, 0);
    chkEq("R7", "busy at done", int'(busy), 1);
    startReq = 1'b0;
    @(negedge clk);
    chkEq("R7", "busy after done", int'(busy), 0);
    chkEq("R7", "done single pulse", int'(done), 0);
  endtask

  task automatic tReset();
    logic [7:0] d;
    chkEq("R1", "rdStrobeN", int'(rdStrobeN), 1);
    chkEq("R1", "wrStrobeN", int'(wrStrobeN), 1);
    chkEq("R1", "busy/done", int'({busy, done, cycFast}), 0);
    chkEq("R1", "udma outputs", int'({udmaTim0, udmaTim1, udmaEn, devFast}), 0);
    for (int a = 'h10; a <= 'h14; a++) begin
      rdReg(8'(a), d);
      chkEq("R1", $sformatf("reg %0h after reset", a), int'(d), 0);
    end
  endtask

  task automatic tRegMap();
    logic [7:0] d;
    wrReg(8'h10, 8'hA5); rdReg(8'h10, d); chkEq("R2", "pio byte", int'(d), 'hA5);
    wrReg(8'h11, 8'h3C); rdReg(8'h11, d); chkEq("R2", "mw byte", int'(d), 'h3C);
    wrReg(8'h12, 8'hFF); rdReg(8'h12, d); chkEq("R2", "udma0 byte", int'(d), 'hF7);
    wrReg(8'h13, 8'h8A); rdReg(8'h13, d); chkEq("R2", "udma1 byte", int'(d), 'h82);
    wrReg(8'h14, 8'hFF); rdReg(8'h14, d); chkEq("R2", "clock byte", int'(d), 'h33);
    chkEq("R10", "udmaTim0", int'(udmaTim0), 'hF7);
    chkEq("R10", "udmaTim1", int'(udmaTim1), 'h82);
    chkEq("R10", "udmaEn", int'(udmaEn), 3);
    chkEq("R10", "devFast", int'(devFast), 3);
    wrReg(8'h14, 8'h21);
    chkEq("R10", "udmaEn split", int'(udmaEn), 2);
    chkEq("R10", "devFast split", int'(devFast), 1);
  endtask

  task automatic tUndef();
    logic [7:0] d;
    wrReg(8'h15, 8'hFF); wrReg(8'h0F, 8'hFF); wrReg(8'h00, 8'h5A);
    rdReg(8'h15, d); chkEq("R3", "read 0x15", int'(d), 0);
    rdReg(8'h0F, d); chkEq("R3", "read 0x0F", int'(d), 0);
    rdReg(8'hFF, d); chkEq("R3", "read 0xFF", int'(d), 0);
    rdReg(8'h10, d); chkEq("R3", "pio untouched", int'(d), 'hA5);
    rdReg(8'h11, d); chkEq("R3", "mw untouched", int'(d), 'h3C);
    rdReg(8'h14, d); chkEq("R3", "clock untouched", int'(d), 'h21);
    rdReg(8'h13, d); chkEq("R3", "udma1 untouched", int'(d), 'h82);
  endtask

  task automatic tPio();
    wrReg(8'h10, 8'h21);
    wrReg(8'h14, 8'h03);
    runCycle(1'b0, 1'b0, 1'b0, 2, 1, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, "R4 pio read");
    runCycle(1'b0, 1'b1, 1'b1, 2, 1, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, "R6 pio write");
  endtask

  task automatic tMw();
    wrReg(8'h11, 8'h03);
    wrReg(8'h14, 8'h02);
    runCycle(1'b1, 1'b1, 1'b1, 0, 3, 1'b1, 1'b0, 1'b0, 8'h0, 8'h0, "R11 mw dev1 fast");
    runCycle(1'b1, 1'b0, 1'b0, 0, 3, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, "R11 mw dev0 slow");
  endtask

  task automatic tExtremes();
    wrReg(8'h10, 8'hF0);
    runCycle(1'b0, 1'b0, 1'b0, 15, 0, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, "R4 max active");
    wrReg(8'h10, 8'h0F);
    runCycle(1'b0, 1'b0, 1'b1, 0, 15, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, "R5 max recovery");
  endtask

  task automatic tGaps();
    wrReg(8'h10, 8'h12);
    refMode = 1;
    runCycle(1'b0, 1'b0, 1'b0, 1, 2, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, "R4 half-rate ref");
    refMode = 2;
    runCycle(1'b0, 1'b1, 1'b1, 1, 2, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, "R5 third-rate ref");
    refMode = 0;
  endtask

  task automatic tBusyIgnore();
    wrReg(8'h11, 8'h11);
    runCycle(1'b1, 1'b0, 1'b0, 1, 1, 1'b0, 1'b1, 1'b0, 8'h0, 8'h0, "R8 request held while busy");
  endtask

  task automatic tMidWrite();
    logic [7:0] d;
    wrReg(8'h10, 8'h21);
    runCycle(1'b0, 1'b0, 1'b0, 2, 1, 1'b0, 1'b0, 1'b1, 8'h10, 8'h54, "R9 write during cycle");
    rdReg(8'h10, d);
    chkEq("R9", "mid-cycle write stored", int'(d), 'h54);
    runCycle(1'b0, 1'b0, 1'b0, 5, 4, 1'b0, 1'b0, 1'b0, 8'h0, 8'h0, "R9 next cycle uses new");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks + 1, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tRegMap();
    tUndef();
    tPio();
    tMw();
    tExtremes();
    tGaps();
    tBusyIgnore();
    tMidWrite();
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule